// File: doc/BRIEF.md
# Five-Channel Ratio-Selectable Clock Divider Bank

The block takes one fast input clock and produces five divided clock channels. Each channel picks its own ratio from bypass (×1), /2, /3, /4, /6, /8 and /16, and drives a pair of single-ended outputs, A and B. Both outputs of a pair carry the same divided waveform. Each output has its own polarity inversion and its own disable.

All channel counters are cleared together by a synchronous active-low reset and start together when it is released. Every divided phase is registered in one shared re-timing stage, so all channels switch after the same input clock edge. Channels with related ratios therefore keep their edges aligned. The configuration arrives as a flat input vector. The block keeps no copy of it, so reset clears the counters and leaves the selected ratios untouched.

Top module: `clkdiv_bank`

## Requirements
- R1: Channel k takes its settings from `cfg_i[7k+6:7k]`. Bits [2:0] hold the ratio code: 000=×1, 001=/2, 010=/3, 011=/4, 100=/6, 101=/8, 110=/16. Bit 3 inverts output A, bit 4 inverts output B, bit 5 disables output A and bit 6 disables output B.
- R2: An even ratio D gives a waveform that is high for D/2 input cycles and low for D/2 cycles. The /3 ratio is high for one input cycle and low for two.
- R3: When both outputs of a channel are enabled, A and B carry the same waveform, apart from their individual inversion.
- R4: An enabled output with its invert bit set carries the complement of the channel waveform.
- R5: A disabled output is held low whatever its invert setting.
- R6: While `rst_n` is low at clock edges, the counters stay at zero. Enabled non-inverted outputs are static low, enabled inverted outputs are static high, and changing the ratio codes has no effect on the outputs.
- R7: Every channel rises on the first clock edge at which `rst_n` is sampled high. A channel of ratio D then rises again every D edges. Each new release of reset restarts this alignment using the ratios present on `cfg_i`.
- R8: With the ×1 code or the reserved code 111, the channel waveform follows the input clock: high during its high phase and low during its low phase, starting with the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset of all counters |
| cfg_i | input | 35 | Per-channel ratio, invert and disable fields, 7 bits per channel |
| clk_a_o | output | 5 | Output A of each channel |
| clk_b_o | output | 5 | Output B of each channel |

## Verification
The hardest situation to reach from the ports is phase alignment across unequal ratios. A /3 and a /16 channel only share a rising edge at the release and then every 48 cycles. A timing error therefore stays hidden in short runs. The bench holds reset, loads mixed ratio sets, releases and runs long enough to cover a common multiple of the ratios. It samples every output in both clock phases, so the bypass channel is seen both high and low. It also re-asserts reset in the middle of a run to show that the restart aligns again without rewriting the configuration.

// File: rtl/clkdiv_pkg.sv
// Shared types and ratio decoding for the clock divider bank.
// Assumes a 7-bit per-channel configuration field; ratio codes fixed by spec.
package clkdiv_pkg;

    localparam int RATIO_W = 3;
    localparam int CH_W    = 7;
    localparam int MAX_DIV = 16;
    localparam int CNT_W   = $clog2(MAX_DIV);

    typedef enum logic [RATIO_W-1:0] {
        DIV_1   = 3'd0,
        DIV_2   = 3'd1,
        DIV_3   = 3'd2,
        DIV_4   = 3'd3,
        DIV_6   = 3'd4,
        DIV_8   = 3'd5,
        DIV_16  = 3'd6,
        DIV_RSV = 3'd7
    } ratio_e;

    typedef struct packed {
        logic   off_b;
        logic   off_a;
        logic   inv_b;
        logic   inv_a;
        ratio_e ratio;
    } chan_cfg_t;

    // Number of input cycles in one output period.
    function automatic logic [CNT_W:0] period_of(ratio_e r);
        case (r)
            DIV_2:   return (CNT_W+1)'(2);
            DIV_3:   return (CNT_W+1)'(3);
            DIV_4:   return (CNT_W+1)'(4);
            DIV_6:   return (CNT_W+1)'(6);
            DIV_8:   return (CNT_W+1)'(8);
            DIV_16:  return (CNT_W+1)'(16);
            default: return (CNT_W+1)'(1);
        endcase
    endfunction

    // Number of input cycles the output stays high per period.
    function automatic logic [CNT_W:0] high_len_of(ratio_e r);
        if (r == DIV_3) return (CNT_W+1)'(1);
        return period_of(r) >> 1;
    endfunction

    // True when the channel passes the input clock straight through.
    function automatic logic is_bypass(ratio_e r);
        return (r == DIV_1) || (r == DIV_RSV);
    endfunction

endpackage

// File: rtl/clkdiv_counter.sv
// One channel's modulo counter and phase generator.
// Counts 0..period-1; phase is high for the first high_len counts.
// Assumes rst_n is synchronous to clk. A count left above a new, shorter
// period wraps to zero on the next edge.
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_e ratio,
    output logic   phase
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   period;
    logic [CNT_W:0]   high_len;
    logic             wrap;

    // Decode ratio into period and high length.
    always_comb begin
        period   = period_of(ratio);
        high_len = high_len_of(ratio);
        wrap     = ({1'b0, cnt} >= (period - 1'b1));
    end

    // Advance the counter, clearing it in reset or at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (wrap)  cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    // Phase level that the shared stage registers on the next edge.
    always_comb begin
        phase = is_bypass(ratio) ? 1'b1 : ({1'b0, cnt} < high_len);
    end

endmodule

// File: rtl/clkdiv_retime.sv
// Common re-timing stage: registers every channel's phase on the same edge.
// Bypass channels gate the input clock with their registered run level.
// Assumes all channels share clk and rst_n.
module clkdiv_retime #(
    parameter int N_CH = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] phase_d,
    input  logic [N_CH-1:0] bypass,
    output logic [N_CH-1:0] phase_q,
    output logic [N_CH-1:0] level
);

    // Capture all channel phases together; reset forces them low.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    // Select clock pass-through or registered phase for each channel.
    always_comb begin
        for (int k = 0; k < N_CH; k++) begin
            level[k] = bypass[k] ? (phase_q[k] & clk) : phase_q[k];
        end
    end

endmodule

// File: rtl/clkdiv_outdrv.sv
// Output driver for one single-ended output: polarity and disable.
// A disabled output is low regardless of its polarity.
module clkdiv_outdrv (
    input  logic level,
    input  logic inv,
    input  logic off,
    output logic y
);

    // Apply disable first, then polarity.
    always_comb begin
        y = off ? 1'b0 : (level ^ inv);
    end

endmodule

// File: rtl/clkdiv_bank.sv
// Top of the divider bank: N_CH channels, each with an A/B output pair.
// Configuration is a flat input vector, 7 bits per channel; it is not stored.
// Assumes rst_n is synchronous and active low.
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int N_CH = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CH*CH_W-1:0] cfg_i,
    output logic [N_CH-1:0]      clk_a_o,
    output logic [N_CH-1:0]      clk_b_o
);

    logic [N_CH-1:0] phase_d;
    logic [N_CH-1:0] bypass;
    logic [N_CH-1:0] phase_q;
    logic [N_CH-1:0] level;

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        chan_cfg_t c;
        // Slice this channel's configuration field.
        always_comb c = chan_cfg_t'(cfg_i[k*CH_W +: CH_W]);
        // Flag channels that pass the input clock straight through.
        always_comb bypass[k] = is_bypass(c.ratio);

        clkdiv_counter u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .ratio (c.ratio),
            .phase (phase_d[k])
        );

        clkdiv_outdrv u_drv_a (
            .level (level[k]),
            .inv   (c.inv_a),
            .off   (c.off_a),
            .y     (clk_a_o[k])
        );

        clkdiv_outdrv u_drv_b (
            .level (level[k]),
            .inv   (c.inv_b),
            .off   (c.off_b),
            .y     (clk_b_o[k])
        );
    end

    clkdiv_retime #(.N_CH(N_CH)) u_retime (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_d (phase_d),
        .bypass  (bypass),
        .phase_q (phase_q),
        .level   (level)
    );

endmodule

// File: rtl/clkdiv_bank_chk.sv
// Assertion checker for clkdiv_bank, attached by bind below.
// Observes ports and the shared re-timing register.
module clkdiv_bank_chk #(
    parameter int N_CH = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_CH*7-1:0]    cfg_i,
    input logic [N_CH-1:0]      clk_a_o,
    input logic [N_CH-1:0]      clk_b_o,
    input logic [N_CH-1:0]      phase_q
);

    logic rst_d;
    logic [N_CH-1:0] rst_out_exp_a;
    logic [N_CH-1:0] rst_out_exp_b;

    for (genvar k = 0; k < N_CH; k++) begin : g_chk
        logic [2:0] r;
        logic ia, ib, oa, ob;
        always_comb begin
            r  = cfg_i[k*7 +: 3];
            ia = cfg_i[k*7 + 3];
            ib = cfg_i[k*7 + 4];
            oa = cfg_i[k*7 + 5];
            ob = cfg_i[k*7 + 6];
            rst_out_exp_a[k] = ia & ~oa;
            rst_out_exp_b[k] = ib & ~ob;
        end

        // R5: disabled outputs stay low.
        p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (oa |-> !clk_a_o[k]) and (ob |-> !clk_b_o[k]));

        // R3: both enabled outputs carry one waveform apart from polarity.
        p_pair_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!oa && !ob) |-> ((clk_a_o[k] ^ ia) == (clk_b_o[k] ^ ib)));

        // R2: a steady /2 channel toggles every edge.
        p_div2_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (r == 3'd1 && $past(r) == 3'd1 && $past(r, 2) == 3'd1 &&
             $past(rst_n) && $past(rst_n, 2))
            |-> (phase_q[k] != $past(phase_q[k])));
    end

    // R7: all channels are high right after the first edge out of reset.
    p_aligned_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rst_n, 2)) |-> (phase_q == '1));

    // R6: outputs hold their static reset levels while reset persists.
    always_ff @(posedge clk) begin
        if (rst_d && !rst_n) begin
            a_reset_levels_r6: assert ((clk_a_o == rst_out_exp_a) &&
                                       (clk_b_o == rst_out_exp_b) &&
                                       (phase_q == '0));
        end
        rst_d <= !rst_n;
    end

endmodule

bind clkdiv_bank clkdiv_bank_chk #(.N_CH(N_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_i   (cfg_i),
    .clk_a_o (clk_a_o),
    .clk_b_o (clk_b_o),
    .phase_q (phase_q)
);

// File: tb/sim_clkdiv_bank.sv
// Directed bench for clkdiv_bank: one task per scenario.
module sim_clkdiv_bank;

    localparam int N = 5;

    logic         clk;
    logic         rst_n;
    logic [N*7-1:0] cfg;
    logic [N-1:0] ya, yb;

    logic [2:0] rat [N];
    logic       inva[N], invb[N], offa[N], offb[N];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    clkdiv_bank u0 (.clk(clk), .rst_n(rst_n), .cfg_i(cfg), .clk_a_o(ya), .clk_b_o(yb));

    initial clk = 0;
    always #5 clk = ~clk;

    // Pack the per-channel settings into the flat vector.
    task automatic apply_cfg();
        for (int k = 0; k < N; k++)
            cfg[k*7 +: 7] = {offb[k], offa[k], invb[k], inva[k], rat[k]};
    endtask

    task automatic set_ch(int k, logic [2:0] r, logic ia, logic ib, logic oa, logic ob);
        rat[k] = r; inva[k] = ia; invb[k] = ib; offa[k] = oa; offb[k] = ob;
    endtask

    // Channel waveform predicted for edge n (1 = first after release).
    function automatic logic exp_lvl(logic [2:0] r, int n, bit hi_half);
        int per, hi;
        case (r)
            3'd1: per = 2;
            3'd2: per = 3;
            3'd3: per = 4;
            3'd4: per = 6;
            3'd5: per = 8;
            3'd6: per = 16;
            default: return hi_half;
        endcase
        hi = (per == 3) ? 1 : per / 2;
        return ((n - 1) % per) < hi;
    endfunction

    task automatic chk1(string tag, int k, string side, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d %s t=%0t: got %b exp %b", tag, k, side, $time, got, exp);
        end
    endtask

    // Compare all outputs against the model for edge n.
    task automatic cmp_all(string tag, int n, bit hi_half);
        for (int k = 0; k < N; k++) begin
            logic l;
            l = exp_lvl(rat[k], n, hi_half);
            chk1(tag, k, "A", ya[k], offa[k] ? 1'b0 : (l ^ inva[k]));
            chk1(tag, k, "B", yb[k], offb[k] ? 1'b0 : (l ^ invb[k]));
        end
    endtask

    // Compare all outputs against their static reset levels.
    task automatic cmp_reset(string tag);
        for (int k = 0; k < N; k++) begin
            chk1(tag, k, "A", ya[k], inva[k] & ~offa[k]);
            chk1(tag, k, "B", yb[k], invb[k] & ~offb[k]);
        end
    endtask

    // Hold reset for some edges, checking static levels in both phases.
    task automatic hold_reset(int edges, string tag);
        rst_n = 0;
        for (int i = 0; i < edges; i++) begin
            @(posedge clk); #2;
            if (i > 0) cmp_reset(tag);
            #5;
            if (i > 0) cmp_reset(tag);
        end
    endtask

    // Release reset and check every edge in both clock phases.
    task automatic run_checked(int cycles, string tag);
        rst_n = 1;
        for (int n = 1; n <= cycles; n++) begin
            @(posedge clk); #2; cmp_all(tag, n, 1'b1);
            #5; cmp_all(tag, n, 1'b0);
        end
    endtask

    // R6: reset levels, and ratio changes during reset have no effect.
    task automatic t_reset_state();
        set_ch(0, 3'd0, 0, 1, 0, 0);
        set_ch(1, 3'd1, 1, 0, 0, 0);
        set_ch(2, 3'd2, 1, 1, 1, 0);
        set_ch(3, 3'd3, 0, 1, 0, 1);
        set_ch(4, 3'd4, 1, 1, 1, 1);
        apply_cfg();
        hold_reset(4, "R6 reset levels");
        for (int k = 0; k < N; k++) rat[k] = 3'd6 - 3'(k);
        apply_cfg();
        hold_reset(3, "R6 ratio change in reset");
    endtask

    // R1/R2/R8: first ratio set, all outputs plain.
    task automatic t_ratios_a();
        set_ch(0, 3'd0, 0, 0, 0, 0);
        set_ch(1, 3'd1, 0, 0, 0, 0);
        set_ch(2, 3'd2, 0, 0, 0, 0);
        set_ch(3, 3'd3, 0, 0, 0, 0);
        set_ch(4, 3'd4, 0, 0, 0, 0);
        apply_cfg();
        hold_reset(2, "R6 before set A");
        run_checked(30, "R1 R2 R8 ratio set A");
    endtask

    // R1/R2/R8/R7: second set incl. /8, /16, reserved code; long run for alignment.
    task automatic t_ratios_b();
        set_ch(0, 3'd5, 0, 0, 0, 0);
        set_ch(1, 3'd6, 0, 0, 0, 0);
        set_ch(2, 3'd7, 0, 0, 0, 0);
        set_ch(3, 3'd2, 0, 0, 0, 0);
        set_ch(4, 3'd1, 0, 0, 0, 0);
        apply_cfg();
        hold_reset(2, "R6 before set B");
        run_checked(50, "R1 R2 R7 R8 ratio set B");
    endtask

    // R3/R4/R5: polarity and disable per output.
    task automatic t_polarity();
        set_ch(0, 3'd2, 1, 0, 0, 0);
        set_ch(1, 3'd3, 0, 1, 0, 0);
        set_ch(2, 3'd0, 1, 1, 0, 0);
        set_ch(3, 3'd4, 1, 0, 1, 0);
        set_ch(4, 3'd6, 0, 1, 0, 1);
        apply_cfg();
        hold_reset(2, "R6 before polarity");
        run_checked(36, "R3 R4 R5 polarity/disable");
    endtask

    // R7: all channels rise on the first edge; mid-run reset restarts alignment.
    task automatic t_align_restart();
        set_ch(0, 3'd6, 0, 0, 0, 0);
        set_ch(1, 3'd2, 0, 0, 0, 0);
        set_ch(2, 3'd4, 0, 0, 0, 0);
        set_ch(3, 3'd5, 0, 0, 0, 0);
        set_ch(4, 3'd0, 0, 0, 0, 0);
        apply_cfg();
        hold_reset(2, "R6 before align");
        rst_n = 1;
        @(posedge clk); #2;
        for (int k = 0; k < N; k++) chk1("R7 first edge high", k, "A", ya[k], 1'b1);
        #5;
        run_checked(0, "");
        for (int n = 2; n <= 13; n++) begin
            @(posedge clk); #2; cmp_all("R7 after first edge", n, 1'b1);
            #5; cmp_all("R7 after first edge", n, 1'b0);
        end
        hold_reset(3, "R6 mid-run reset");
        run_checked(40, "R7 restart keeps ratios");
    endtask

    // R2: count /3 high cycles over a 9-cycle window.
    task automatic t_duty3();
        int highs;
        set_ch(0, 3'd2, 0, 0, 0, 0);
        for (int k = 1; k < N; k++) set_ch(k, 3'd3, 0, 0, 0, 0);
        apply_cfg();
        hold_reset(2, "R6 before duty");
        rst_n = 1;
        highs = 0;
        for (int n = 1; n <= 9; n++) begin
            @(posedge clk); #2;
            if (ya[0]) highs++;
            #5;
        end
        n_chk++;
        if (highs != 3) begin
            n_fail++;
            $display("FAIL R2 div3 duty: got %0d high cycles exp %0d", highs, 3);
        end
    endtask

    initial begin
        rst_n = 0;
        cfg   = '0;
        for (int k = 0; k < N; k++) set_ch(k, 3'd0, 0, 0, 0, 0);
        #1;
        t_reset_state();
        t_ratios_a();
        t_ratios_b();
        t_polarity();
        t_align_restart();
        t_duty3();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule